// File: doc/BRIEF.md
# Event Flag and Interrupt Controller for a Two-Wire Bus Master

This block gathers the one-cycle event pulses produced by a two-wire bus master engine and holds each one in a sticky flag until software acknowledges it. A processor reaches the flags through a small 16-bit register port with four word addresses. One address gives the unfiltered flag word that polling software reads. A second address gives the same word filtered by an enable mask, and it is also where software writes ones to acknowledge flags. Two further addresses add bits to the enable mask or remove bits from it, so software never needs a read-modify-write cycle.

The flag word also carries a live bus-in-use level, which software can poll before it starts a transfer. A single registered interrupt line goes high while any enabled flag is pending. Flags whose enable bit is clear are still recorded and can still be polled.

Event bit positions, which both the flag word and the enable mask use: bit 0 arbitration lost, bit 1 no-acknowledge, bit 2 access ready (transfer finished), bit 3 receive ready, bit 4 transmit ready, bit 5 access error, bit 6 receive overrun. Bit 12 is the bus-in-use level. Every other bit reads as zero.

Top module: `twb_irq_unit`

## Requirements
- R1: After reset, every event flag is 0, the enable mask is 0 and `irq_o` is 0. The flag word then reads 0, apart from bit 12, which follows `bus_busy_i`.
- R2: A high bit of `evt_i` at a clock edge sets the event flag at the same bit position (bit 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 access error, 6 receive overrun). The flag stays set until it is acknowledged, whatever the enable mask holds, and it can be read at address 0.
- R3: Address 1 reads the event flags ANDed with the enable mask. Bit 12 and the unused bits of this view read 0.
- R4: A write to address 1 clears each event flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R5: If an event pulse and an acknowledge for the same bit fall in the same cycle, the flag ends up set.
- R6: A write to address 2 ORs the data into the enable mask. A write to address 3 clears each mask bit whose data bit is 1. The mask reads back at both address 2 and address 3.
- R7: `irq_o` rises one cycle after an enabled flag becomes pending. It falls one cycle after the last enabled pending flag is cleared or disabled.
- R8: Bit 12 of the address-0 word follows `bus_busy_i` with no latching. Acknowledge writes do not affect it, a high bus-busy level never drives `irq_o`, and a write of 0x7fff to address 1 clears every event flag in one access.
- R9: A write to address 0 changes neither the flags nor the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | One-cycle event pulses from the bus engine |
| bus_busy_i | input | 1 | Live bus-in-use level |
| reg_addr_i | input | 2 | Register word address: 0 flags, 1 filtered/acknowledge, 2 enable add, 3 enable remove |
| reg_wr_i | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Flags and mask bits change at the clock edge that samples the pulse or the write, so their read values are due one edge later. The interrupt line adds one more register and is due two edges after the cause. The bench drives every input on the falling edge and samples on the falling edge. It reads a flag or mask right after the edge that updates it, and it checks `irq_o` twice: first at the sample point where it must not have moved yet, then one cycle later where it must have moved. This confirms the exact latency rather than only the eventual value.

// File: rtl/twb_irq_pkg.sv
package twb_irq_pkg;
  typedef enum logic [1:0] {
    ADR_RAW    = 2'd0,
    ADR_MASKED = 2'd1,
    ADR_ENSET  = 2'd2,
    ADR_ENCLR  = 2'd3
  } twb_adr_e;

  localparam int EV_ARB_LOST = 0;
  localparam int EV_NACK     = 1;
  localparam int EV_ACC_RDY  = 2;
  localparam int EV_RX_RDY   = 3;
  localparam int EV_TX_RDY   = 4;
  localparam int EV_ACC_ERR  = 5;
  localparam int EV_RX_OVR   = 6;
endpackage

// File: rtl/twb_flag_bank.sv
module twb_flag_bank #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] ack_i,
  output logic [NUM_EVT-1:0] flags_o
);
  logic [NUM_EVT-1:0] flags_q;

  function automatic logic [NUM_EVT-1:0] next_flags(
    input logic [NUM_EVT-1:0] cur,
    input logic [NUM_EVT-1:0] ev,
    input logic [NUM_EVT-1:0] ack
  );
    return (cur & ~ack) | ev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, evt_i, ack_i);
  end

  assign flags_o = flags_q;

  // R5: a pulse always leaves its flag set, even against an acknowledge
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  // R4: acknowledged bits without a fresh pulse are cleared
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_i & ~evt_i) != '0) |=> ((flags_q & $past(ack_i & ~evt_i)) == '0));

  // R2: flags are sticky when nothing touches them
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0 && ack_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/twb_enable_mask.sv
module twb_enable_mask #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] en_o
);
  logic [NUM_EVT-1:0] en_q;

  function automatic logic [NUM_EVT-1:0] next_mask(
    input logic [NUM_EVT-1:0] cur,
    input logic [NUM_EVT-1:0] s,
    input logic [NUM_EVT-1:0] c
  );
    return (cur | s) & ~c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= next_mask(en_q, set_i, clr_i);
  end

  assign en_o = en_q;

  // R6: set writes add bits, clear writes remove them
  a_r6_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0 && clr_i == '0) |=> ((en_q & $past(set_i)) == $past(set_i)));
  a_r6_clr_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((en_q & $past(clr_i)) == '0));
endmodule

// File: rtl/twb_irq_gen.sv
module twb_irq_gen #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] flags_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic               irq_o
);
  logic pending;
  logic irq_q;

  assign pending = |(flags_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/twb_irq_unit.sv
module twb_irq_unit
  import twb_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_EVT  = 7,
  parameter int BUSY_BIT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_busy_i,
  input  logic [1:0]         reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  localparam int EV_W = NUM_EVT;

  logic [EV_W-1:0] wr_ack, wr_set, wr_clr;
  logic [EV_W-1:0] flags, en_mask;
  logic [DATA_W-1:0] raw_word, masked_word, en_word;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:EV_W];

  assign wr_ack = (reg_wr_i && reg_addr_i == ADR_MASKED) ? reg_wdata_i[EV_W-1:0] : '0;
  assign wr_set = (reg_wr_i && reg_addr_i == ADR_ENSET)  ? reg_wdata_i[EV_W-1:0] : '0;
  assign wr_clr = (reg_wr_i && reg_addr_i == ADR_ENCLR)  ? reg_wdata_i[EV_W-1:0] : '0;

  twb_flag_bank #(.NUM_EVT(EV_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack_i(wr_ack), .flags_o(flags)
  );

  twb_enable_mask #(.NUM_EVT(EV_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(wr_set), .clr_i(wr_clr), .en_o(en_mask)
  );

  twb_irq_gen #(.NUM_EVT(EV_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .en_i(en_mask), .irq_o(irq_o)
  );

  always_comb begin
    raw_word = '0;
    raw_word[EV_W-1:0] = flags;
    raw_word[BUSY_BIT] = bus_busy_i;
    masked_word = '0;
    masked_word[EV_W-1:0] = flags & en_mask;
    en_word = '0;
    en_word[EV_W-1:0] = en_mask;
  end

  always_comb begin
    unique case (reg_addr_i)
      ADR_RAW:    reg_rdata_o = raw_word;
      ADR_MASKED: reg_rdata_o = masked_word;
      default:    reg_rdata_o = en_word;
    endcase
  end

  // R7: the line follows the enabled pending state one cycle later
  a_r7_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(flags & en_mask))));

  // R9: writes to the flag-word address alter nothing
  a_r9_raw_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == ADR_RAW && evt_i == '0) |=> ($stable(flags) && $stable(en_mask)));

  // R3: the filtered view never shows a disabled flag
  a_r3_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_word[EV_W-1:0] & ~en_mask) == '0));
endmodule

// File: tb/tb_twb_irq_unit.sv
module tb_twb_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        busy = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  twb_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_busy_i(busy),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_read(2'd0, v); check("R1 flags", v, 16'h0000);
    reg_read(2'd2, v); check("R1 mask", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_latch_disabled();
    logic [15:0] v;
    pulse(7'h08);
    reg_read(2'd0, v); check("R2 rx_ready flag", v, 16'h0008);
    reg_read(2'd1, v); check("R3 masked when disabled", v, 16'h0000);
    @(negedge clk);
    check("R2 no irq when disabled", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    reg_write(2'd2, 16'h0009);
    reg_read(2'd2, v); check("R6 mask at set addr", v, 16'h0009);
    reg_read(2'd3, v); check("R6 mask at clr addr", v, 16'h0009);
    reg_read(2'd1, v); check("R3 masked view", v, 16'h0008);
    check("R7 irq not yet", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R7 irq one cycle later", {15'd0, irq}, 16'h0001);
    reg_write(2'd3, 16'h0008);
    reg_read(2'd2, v); check("R6 mask after clear", v, 16'h0001);
    check("R7 irq still high", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    check("R7 irq falls", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    pulse(7'h7f);
    reg_read(2'd0, v); check("R2 all events", v, 16'h007f);
    reg_write(2'd1, 16'h0005);
    reg_read(2'd0, v); check("R4 partial ack", v, 16'h007a);
    reg_write(2'd0, 16'hffff);
    reg_read(2'd0, v); check("R9 flags after raw write", v, 16'h007a);
    reg_read(2'd2, v); check("R9 mask after raw write", v, 16'h0001);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    @(negedge clk);
    evt = 7'h02; addr = 2'd1; wdata = 16'h0002; wr = 1'b1;
    @(negedge clk);
    evt = '0; wr = 1'b0;
    reg_read(2'd0, v); check("R5 event beats ack", v, 16'h007a);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    @(negedge clk);
    busy = 1'b1;
    reg_read(2'd0, v); check("R8 busy visible", v, 16'h107a);
    reg_write(2'd1, 16'h7fff);
    reg_read(2'd0, v); check("R8 clear all keeps busy", v, 16'h1000);
    reg_read(2'd1, v); check("R3 busy absent in masked", v, 16'h0000);
    reg_write(2'd2, 16'h007f);
    @(negedge clk);
    @(negedge clk);
    check("R8 busy gives no irq", {15'd0, irq}, 16'h0000);
    busy = 1'b0;
    reg_read(2'd0, v); check("R8 busy live drop", v, 16'h0000);
  endtask

  task automatic t_irq_ack();
    pulse(7'h10);
    check("R7 irq not yet after event", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R7 irq set by tx_ready", {15'd0, irq}, 16'h0001);
    reg_write(2'd1, 16'h0010);
    check("R7 irq one more cycle", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    check("R7 irq falls after ack", {15'd0, irq}, 16'h0000);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_disabled();
    t_enable();
    t_ack();
    t_collide();
    t_busy();
    t_irq_ack();
    finished = 1;
    summary();
  end

  initial begin
    #100000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule